// File: doc/BRIEF.md
# Host-Side Converter Sequencer

This block runs a successive-approximation converter from the host side. A single request, taken in one cycle, becomes a full sequence on the converter's control pins. The sequence sets chip select and byte enable, gives them a setup window, and pulses the read/convert line low. It then waits for the converter's busy line to go low and come back high. The result is read either as one 12-bit word or as two byte reads over an 8-bit path. The finished result leaves on a one-cycle valid strobe.

Each request chooses one of two pulse styles. In the negative-pulse style, read/convert drops, comes back high while the conversion runs, and the fresh result is read once busy returns high. In the positive-pulse style, read/convert is raised and the result of the previous conversion is read during that high phase. The following falling edge then starts the next conversion, and the line stays low until the next request. Reading one result therefore overlaps with starting the next conversion. A counter watches every conversion and reports a timeout if busy does not come back high within a limit the host sets.

Top module: `conv_seq`

## Requirements
- R1: After reset, chip select (active low) is high, read/convert is high, high-byte enable is low, result valid and timeout are low, and request ready is high.
- R2: Request ready is high only while the sequencer is idle, and chip select is high whenever it is. A request offered while ready is low is ignored and produces no result.
- R3: Negative-pulse mode: read/convert is driven low and then high again before the conversion ends. The data is read only after busy returns high, and the reported result is the value converted by this request's start. After such a sequence, read/convert idles high.
- R4: Positive-pulse mode: read/convert is raised and the result of the previous conversion is read while it is high. A falling edge then starts the next conversion, and read/convert stays low while idle until the next request.
- R5: Every low phase of read/convert lasts at least ceil(LOW_NS/CLK_NS) clock cycles (4 by default).
- R6: At every read/convert falling edge, chip select is low and high-byte enable is low. Both have held those values for at least ceil(SETUP_NS/CLK_NS) cycles (3 by default).
- R7: No read/convert falling edge is issued while busy is low. A request that arrives while a conversion is still running waits for busy to return high before it starts.
- R8: Byte mode: two reads are made. With high-byte enable high, result bits 11:8 come in on data bits 3:0. With it low, result bits 7:0 come in on data bits 7:0. Word mode makes one read with high-byte enable low and takes all 12 data bits.
- R9: Result valid is a one-cycle pulse that carries the assembled 12-bit result. It is raised once per completed read sequence, and data is sampled only while busy is high.
- R10: If busy has not returned high within tmoLimit cycles of the start edge, timeout pulses for one cycle and no result is produced. The sequencer then returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, taken when reqReady is high |
| reqPosPulse | input | 1 | 1 selects positive-pulse style, 0 selects negative-pulse style |
| reqByteMode | input | 1 | 1 reads the result as two bytes, 0 as one word |
| reqReady | output | 1 | High while idle |
| tmoLimit | input | TMO_W | Maximum cycles from start edge to busy returning high |
| resValid | output | 1 | One-cycle result strobe |
| resData | output | DATA_W | Assembled result |
| tmoErr | output | 1 | One-cycle conversion timeout strobe |
| adcCsN | output | 1 | Converter chip select, active low |
| adcRc | output | 1 | Converter read/convert line |
| adcHbe | output | 1 | Converter high-byte enable |
| adcBusyN | input | 1 | Converter busy, low during conversion |
| adcData | input | DATA_W | Converter data bus |

## Verification
The bench drives a behavioural converter with values that tell the two pulse styles apart. The all-zero, all-one and mixed words fed in negative-pulse mode must come back unchanged. In positive-pulse mode every result must equal the value converted by the request before, which exposes any loss of the one-request lag. Byte-mode values with different high and low halves show whether the high nibble is placed and combined correctly. One deliberately long conversion separates a correct timeout from a false one, and the request that follows it, made while busy is still low, shows whether the start is held back. A request pulsed during a running sequence checks that requests outside idle are ignored.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PREP,
    ST_START,
    ST_WLO,
    ST_WHI,
    ST_RDHI,
    ST_RDLO
  } seqState_t;

  typedef enum logic [1:0] {
    CNT_SETUP,
    CNT_LOW,
    CNT_READ
  } cntSel_t;

  typedef struct packed {
    logic    csAssert;
    logic    csRelease;
    logic    rcDrop;
    logic    rcRaise;
    logic    hbeSet;
    logic    hbeClr;
    logic    cntLoad;
    cntSel_t cntSel;
    logic    tmoClear;
    logic    capHigh;
    logic    capLow;
    logic    capWord;
    logic    resultStb;
    logic    timeoutStb;
  } seqStrobe_t;

  function automatic int nsToCycles(input int ns, input int clkNs);
    int c;
    c = (ns + clkNs - 1) / clkNs;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/conv_seq_ctrl.sv
module conv_seq_ctrl
  import conv_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqPosPulse,
  input  logic       reqByteMode,
  output logic       reqReady,
  input  logic       busyN,
  input  logic       cntDone,
  input  logic       tmoHit,
  output seqStrobe_t stb
);

  seqState_t state, nxt;
  logic      posQ;
  logic      byteQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      posQ  <= 1'b0;
      byteQ <= 1'b0;
    end else begin
      state <= nxt;
      if (state == ST_IDLE && reqValid) begin
        posQ  <= reqPosPulse;
        byteQ <= reqByteMode;
      end
    end
  end

  assign reqReady = (state == ST_IDLE);

  always_comb begin
    nxt = state;
    stb = '0;
    stb.cntSel = CNT_SETUP;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          stb.csAssert = 1'b1;
          stb.rcRaise  = 1'b1;
          stb.cntLoad  = 1'b1;
          if (reqPosPulse) begin
            stb.cntSel = CNT_READ;
            if (reqByteMode) begin
              stb.hbeSet = 1'b1;
              nxt = ST_RDHI;
            end else begin
              stb.hbeClr = 1'b1;
              nxt = ST_RDLO;
            end
          end else begin
            stb.cntSel = CNT_SETUP;
            stb.hbeClr = 1'b1;
            nxt = ST_PREP;
          end
        end
      end
      ST_PREP: begin
        if (cntDone && busyN) begin
          stb.rcDrop   = 1'b1;
          stb.cntLoad  = 1'b1;
          stb.cntSel   = CNT_LOW;
          stb.tmoClear = 1'b1;
          nxt = ST_START;
        end
      end
      ST_START: begin
        if (cntDone) begin
          if (!posQ) stb.rcRaise = 1'b1;
          nxt = ST_WLO;
        end
      end
      ST_WLO: begin
        if (tmoHit) begin
          stb.csRelease  = 1'b1;
          stb.timeoutStb = 1'b1;
          nxt = ST_IDLE;
        end else if (!busyN) begin
          nxt = ST_WHI;
        end
      end
      ST_WHI: begin
        if (busyN) begin
          if (posQ) begin
            stb.csRelease = 1'b1;
            nxt = ST_IDLE;
          end else begin
            stb.cntLoad = 1'b1;
            stb.cntSel  = CNT_READ;
            if (byteQ) begin
              stb.hbeSet = 1'b1;
              nxt = ST_RDHI;
            end else begin
              nxt = ST_RDLO;
            end
          end
        end else if (tmoHit) begin
          stb.csRelease  = 1'b1;
          stb.timeoutStb = 1'b1;
          nxt = ST_IDLE;
        end
      end
      ST_RDHI: begin
        stb.cntSel = CNT_READ;
        if (!busyN) begin
          stb.cntLoad = 1'b1;
        end else if (cntDone) begin
          stb.capHigh = 1'b1;
          stb.hbeClr  = 1'b1;
          stb.cntLoad = 1'b1;
          nxt = ST_RDLO;
        end
      end
      ST_RDLO: begin
        stb.cntSel = CNT_READ;
        if (!busyN) begin
          stb.cntLoad = 1'b1;
        end else if (cntDone) begin
          stb.capLow    = byteQ;
          stb.capWord   = !byteQ;
          stb.resultStb = 1'b1;
          if (posQ) begin
            stb.cntLoad = 1'b1;
            stb.cntSel  = CNT_SETUP;
            nxt = ST_PREP;
          end else begin
            stb.csRelease = 1'b1;
            nxt = ST_IDLE;
          end
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/conv_seq_dp.sv
module conv_seq_dp
  import conv_seq_pkg::*;
#(
  parameter int DATA_W    = 12,
  parameter int BUS_W     = 8,
  parameter int TMO_W     = 16,
  parameter int SETUP_CYC = 3,
  parameter int LOW_CYC   = 4,
  parameter int READ_CYC  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        stb,
  input  logic [TMO_W-1:0]  tmoLimit,
  input  logic [DATA_W-1:0] adcData,
  output logic              cntDone,
  output logic              tmoHit,
  output logic              adcCsN,
  output logic              adcRc,
  output logic              adcHbe,
  output logic              resValid,
  output logic [DATA_W-1:0] resData,
  output logic              tmoErr
);

  localparam int HI_W  = DATA_W - BUS_W;
  localparam int MAXC0 = (SETUP_CYC > LOW_CYC) ? SETUP_CYC : LOW_CYC;
  localparam int MAXC  = (MAXC0 > READ_CYC) ? MAXC0 : READ_CYC;
  localparam int CNT_W = (MAXC < 2) ? 1 : $clog2(MAXC);

  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  loadVal;
  logic [TMO_W-1:0]  tmoCnt;
  logic [DATA_W-1:0] byteWord;

  always_comb begin
    unique case (stb.cntSel)
      CNT_LOW:  loadVal = CNT_W'(LOW_CYC - 1);
      CNT_READ: loadVal = CNT_W'(READ_CYC - 1);
      default:  loadVal = CNT_W'(SETUP_CYC - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (stb.cntLoad) begin
      cnt <= loadVal;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign cntDone = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tmoCnt <= '0;
    end else if (stb.tmoClear) begin
      tmoCnt <= '0;
    end else if (tmoCnt != '1) begin
      tmoCnt <= tmoCnt + 1'b1;
    end
  end

  assign tmoHit = (tmoCnt >= tmoLimit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      adcCsN <= 1'b1;
      adcRc  <= 1'b1;
      adcHbe <= 1'b0;
    end else begin
      if (stb.csAssert)       adcCsN <= 1'b0;
      else if (stb.csRelease) adcCsN <= 1'b1;
      if (stb.rcDrop)         adcRc  <= 1'b0;
      else if (stb.rcRaise)   adcRc  <= 1'b1;
      if (stb.hbeSet)         adcHbe <= 1'b1;
      else if (stb.hbeClr)    adcHbe <= 1'b0;
    end
  end

  generate
    if (HI_W > 0) begin : g_split
      logic [HI_W-1:0] hiNib;
      always_ff @(posedge clk) begin
        if (!rstN) hiNib <= '0;
        else if (stb.capHigh) hiNib <= adcData[HI_W-1:0];
      end
      assign byteWord = {hiNib, adcData[BUS_W-1:0]};
    end else begin : g_whole
      assign byteWord = adcData;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resData  <= '0;
      resValid <= 1'b0;
      tmoErr   <= 1'b0;
    end else begin
      if (stb.capWord)     resData <= adcData;
      else if (stb.capLow) resData <= byteWord;
      resValid <= stb.resultStb;
      tmoErr   <= stb.timeoutStb;
    end
  end

endmodule

// File: rtl/conv_seq.sv
module conv_seq
  import conv_seq_pkg::*;
#(
  parameter int DATA_W    = 12,
  parameter int BUS_W     = 8,
  parameter int TMO_W     = 16,
  parameter int CLK_NS    = 10,
  parameter int SETUP_NS  = 25,
  parameter int LOW_NS    = 40,
  parameter int ACCESS_NS = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqPosPulse,
  input  logic              reqByteMode,
  output logic              reqReady,
  input  logic [TMO_W-1:0]  tmoLimit,
  output logic              resValid,
  output logic [DATA_W-1:0] resData,
  output logic              tmoErr,
  output logic              adcCsN,
  output logic              adcRc,
  output logic              adcHbe,
  input  logic              adcBusyN,
  input  logic [DATA_W-1:0] adcData
);

  localparam int SETUP_CYC = nsToCycles(SETUP_NS, CLK_NS);
  localparam int LOW_CYC   = nsToCycles(LOW_NS, CLK_NS);
  localparam int READ_CYC  = nsToCycles(ACCESS_NS, CLK_NS);

  seqStrobe_t stb;
  logic       cntDone;
  logic       tmoHit;

  conv_seq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqPosPulse(reqPosPulse),
    .reqByteMode(reqByteMode),
    .reqReady   (reqReady),
    .busyN      (adcBusyN),
    .cntDone    (cntDone),
    .tmoHit     (tmoHit),
    .stb        (stb)
  );

  conv_seq_dp #(
    .DATA_W   (DATA_W),
    .BUS_W    (BUS_W),
    .TMO_W    (TMO_W),
    .SETUP_CYC(SETUP_CYC),
    .LOW_CYC  (LOW_CYC),
    .READ_CYC (READ_CYC)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .tmoLimit(tmoLimit),
    .adcData (adcData),
    .cntDone (cntDone),
    .tmoHit  (tmoHit),
    .adcCsN  (adcCsN),
    .adcRc   (adcRc),
    .adcHbe  (adcHbe),
    .resValid(resValid),
    .resData (resData),
    .tmoErr  (tmoErr)
  );

endmodule

// File: rtl/conv_seq_chk.sv
module conv_seq_chk #(
  parameter int SETUP_CYC = 3,
  parameter int LOW_CYC   = 4
) (
  input logic clk,
  input logic rstN,
  input logic reqReady,
  input logic resValid,
  input logic tmoErr,
  input logic adcCsN,
  input logic adcRc,
  input logic adcHbe,
  input logic adcBusyN
);

  logic csQ;
  logic hbeQ;
  int   setupRun;
  int   lowRun;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csQ      <= 1'b1;
      hbeQ     <= 1'b0;
      setupRun <= 0;
      lowRun   <= 0;
    end else begin
      csQ  <= adcCsN;
      hbeQ <= adcHbe;
      if (adcCsN != csQ || adcHbe != hbeQ) setupRun <= 1;
      else if (setupRun < 1000000)         setupRun <= setupRun + 1;
      if (adcRc)                  lowRun <= 0;
      else if (lowRun < 1000000)  lowRun <= lowRun + 1;
    end
  end

  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> adcCsN);  // R2

  AST_START_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    $fell(adcRc) |-> $past(adcBusyN));  // R7

  AST_SETUP_HELD: assert property (@(posedge clk) disable iff (!rstN)
    $fell(adcRc) |-> (!adcCsN && !adcHbe && setupRun >= SETUP_CYC));  // R6

  AST_LOW_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(adcRc) |-> (lowRun >= LOW_CYC));  // R5

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> !resValid);  // R9

  AST_READ_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> $past(adcBusyN));  // R9

  AST_TMO_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    tmoErr |=> !tmoErr);  // R10

  AST_TMO_NO_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    tmoErr |-> (!resValid && reqReady));  // R10

endmodule

bind conv_seq conv_seq_chk #(
  .SETUP_CYC(SETUP_CYC),
  .LOW_CYC  (LOW_CYC)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .reqReady(reqReady),
  .resValid(resValid),
  .tmoErr  (tmoErr),
  .adcCsN  (adcCsN),
  .adcRc   (adcRc),
  .adcHbe  (adcHbe),
  .adcBusyN(adcBusyN)
);

// File: tb/conv_seq_tb.sv
`timescale 1ns/1ps
module conv_seq_tb;

  localparam int SETUPC = (25 + 9) / 10;
  localparam int LOWC   = (40 + 9) / 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqPosPulse = 1'b0;
  logic        reqByteMode = 1'b0;
  logic        reqReady;
  logic [15:0] tmoLimit = 16'd100;
  logic        resValid;
  logic [11:0] resData;
  logic        tmoErr;
  logic        adcCsN, adcRc, adcHbe;
  logic        adcBusyN;
  logic [11:0] adcData;

  int checks = 0;
  int errors = 0;
  int tmoSeen = 0;
  logic [11:0] expQ[$];

  always #5 clk = ~clk;

  conv_seq u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqPosPulse(reqPosPulse),
    .reqByteMode(reqByteMode), .reqReady(reqReady), .tmoLimit(tmoLimit),
    .resValid(resValid), .resData(resData), .tmoErr(tmoErr),
    .adcCsN(adcCsN), .adcRc(adcRc), .adcHbe(adcHbe),
    .adcBusyN(adcBusyN), .adcData(adcData)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural converter model
  logic [11:0] analogVal = 12'h000;
  logic [11:0] pending = 12'h000;
  logic [11:0] convResult = 12'h5A5;
  int          convLen = 20;
  int          busyCnt = 0;
  logic        mRcQ = 1'b1, mCsQ = 1'b1, mHbeQ = 1'b0;
  int          mSetup = 0, mLow = 0;
  logic        busyReg = 1'b1;

  assign adcBusyN = busyReg;
  assign adcData = (!adcCsN && adcRc && adcBusyN)
                   ? (adcHbe ? {8'h00, convResult[11:8]} : convResult)
                   : 12'hEEE;

  always @(posedge clk) begin
    if (!rstN) begin
      mRcQ <= 1'b1; mCsQ <= 1'b1; mHbeQ <= 1'b0;
      mSetup <= 0; mLow <= 0; busyReg <= 1'b1;
    end else begin
      mRcQ <= adcRc; mCsQ <= adcCsN; mHbeQ <= adcHbe;
      if (adcCsN != mCsQ || adcHbe != mHbeQ) mSetup <= 1;
      else mSetup <= mSetup + 1;
      if (adcRc) begin
        if (!mRcQ) chk("R5 low phase cycles", (mLow >= LOWC), 1);
        mLow <= 0;
      end else begin
        mLow <= mLow + 1;
      end
      if (mRcQ && !adcRc) begin
        chk("R6 cs/hbe at edge", {adcCsN, adcHbe}, 2'b00);
        chk("R6 setup cycles", (mSetup >= SETUPC), 1);
        chk("R7 start while busy", busyReg, 1'b1);
        if (busyReg && !adcCsN && !adcHbe) begin
          busyReg <= 1'b0;
          busyCnt <= convLen;
          pending <= analogVal;
        end
      end else if (!busyReg) begin
        if (busyCnt <= 1) begin
          busyReg <= 1'b1;
          convResult <= pending;
        end else begin
          busyCnt <= busyCnt - 1;
        end
      end
    end
  end

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (resValid) begin
        if (expQ.size() == 0) begin
          chk("R9 unexpected result", {20'h0, resData}, 32'hFFFFFFFF);
        end else begin
          logic [11:0] e;
          e = expQ.pop_front();
          chk("R3/R4/R8 result", {20'h0, resData}, {20'h0, e});
        end
      end
      if (tmoErr) tmoSeen++;
    end
  end

  logic [11:0] prevConv = 12'h5A5;

  task automatic issue(input bit pos, input bit byt, input logic [11:0] val, input bit expectOk);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    if (expectOk) expQ.push_back(pos ? prevConv : val);
    analogVal   = val;
    reqPosPulse = pos;
    reqByteMode = byt;
    reqValid    = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    prevConv = val;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 csN", adcCsN, 1);
    chk("R1 rc", adcRc, 1);
    chk("R1 hbe", adcHbe, 0);
    chk("R1 resValid", resValid, 0);
    chk("R1 tmoErr", tmoErr, 0);
    chk("R1 reqReady", reqReady, 1);

    // R3 negative pulse, word mode
    issue(0, 0, 12'h000, 1);
    issue(0, 0, 12'hFFF, 1);
    issue(0, 0, 12'hA5C, 1);
    chk("R3 rc idles high", adcRc, 1);
    // R8 byte mode, negative pulse
    issue(0, 1, 12'h123, 1);
    issue(0, 1, 12'hF0F, 1);
    // R4 positive pulse, word and byte
    issue(1, 0, 12'h777, 1);
    chk("R4 rc idles low", adcRc, 0);
    issue(1, 0, 12'h0F1, 1);
    issue(1, 1, 12'h8E2, 1);
    issue(1, 1, 12'h456, 1);
    chk("R4 rc idles low after byte", adcRc, 0);
    issue(0, 0, 12'h9AB, 1);
    chk("R3 rc back high", adcRc, 1);

    // R2 request outside idle is ignored
    fork
      issue(0, 1, 12'h6D4, 1);
      begin
        repeat (10) @(negedge clk);
        chk("R2 ready low while busy", reqReady, 0);
        reqPosPulse = 1'b1;
        reqValid = 1'b1;
        @(negedge clk);
        reqValid = 1'b0;
      end
    join
    repeat (5) @(negedge clk);
    chk("R2 no extra result", expQ.size(), 0);

    // R10 timeout
    convLen = 200;
    tmoLimit = 16'd40;
    issue(0, 0, 12'h321, 0);
    chk("R10 timeout pulse", tmoSeen, 1);
    chk("R10 back to idle", reqReady, 1);
    // R7 request while busy still low must wait
    chk("R7 busy still low", adcBusyN, 0);
    convLen = 20;
    tmoLimit = 16'd100;
    issue(0, 1, 12'hBEE, 1);
    chk("R7 no further timeout", tmoSeen, 1);

    repeat (20) @(negedge clk);
    chk("R9 all results delivered", expQ.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule